// File: doc/BRIEF.md
# Preloaded Valid/Ready FIFO Buffer

This block is a synchronous first-in first-out buffer with a valid/ready handshake on each side. A word moves in when the producer asserts `in_valid` while `in_ready` is high, and moves out when the consumer asserts `out_ready` while `out_valid` is high. Both transfers are qualified by a clock enable `en`. The buffer separates a producer from a consumer, so neither has to wait for the other on every cycle.

When the synchronous reset is released, the buffer already holds `PRELOAD_N` words taken from a parameter vector. They are held in index order, and index 0 is presented first. This lets the buffer seed a feedback loop with initial tokens. The buffer drives both `in_ready` and `out_valid` straight from registers. As a result, no combinational path runs through it from the input side to the output side or back. This makes it safe to place on parallel branches that are later joined or forked in lock-step.

Top module: `preload_fifo`

## Requirements
- R1: In the first cycle after reset, the occupancy equals `PRELOAD_N`. `out_valid` is high exactly when `PRELOAD_N > 0`, and `out_data` shows preload entry 0, which is bits `[WIDTH-1:0]` of `PRELOAD_DATA`. Entry k sits at bits `[k*WIDTH +: WIDTH]`.
- R2: The occupancy never exceeds `DEPTH`. After reset, exactly `DEPTH - PRELOAD_N` words are accepted before `in_ready` goes low.
- R3: Words leave in arrival order. The preloaded entries come first, in index order, followed by the pushed words.
- R4: No word is written while `in_valid` is low. Holding `in_valid` low with data on `in_data` adds nothing to the contents.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays unchanged on the next cycle.
- R6: While `en` is low, no word is accepted or removed, and `in_ready`, `out_valid` and `out_data` hold their values.
- R7: `out_valid` is high exactly when the occupancy is nonzero. `in_ready` is high exactly when the occupancy is below `DEPTH`. A word pushed into an empty buffer appears at the output one cycle after it is accepted.
- R8: When the buffer is full, a push is refused even if a pop happens in the same cycle. `in_ready` rises in the cycle after that pop.
- R9: When the buffer is empty, `out_valid` is low and an asserted `out_ready` removes nothing.
- R10: A change on `out_ready` never changes `in_ready` within the same cycle, and a change on `in_valid` never changes `out_valid` within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low; loads the preload contents |
| en | input | 1 | Clock enable; when low, all state holds |
| in_data | input | WIDTH | Word offered by the producer |
| in_valid | input | 1 | Producer has a word on `in_data` |
| in_ready | output | 1 | Buffer can accept a word this cycle (registered) |
| out_data | output | WIDTH | Word at the head of the buffer |
| out_valid | output | 1 | `out_data` holds a stored word (registered) |
| out_ready | input | 1 | Consumer takes the head word this cycle |

## Verification
A corrupted read pointer or stale storage slot shows up at the very next pop as a word out of order. The scoreboard compares every transfer against the expected sequence, so it catches this on the first bad word. A wrong occupancy count shows as `in_ready` or `out_valid` disagreeing with the number of words pushed and popped. This mismatch appears one cycle after the transfer that caused it, for example `in_ready` staying high after the last free slot is filled. A wrong preload shows in the first cycle after reset, both as the head word and as the number of pushes accepted before `in_ready` drops.

// File: rtl/preload_fifo_pkg.sv
// Shared types for the preloaded FIFO buffer.
package preload_fifo_pkg;

    // Transfers that take place at the coming clock edge.
    typedef struct packed {
        logic push;
        logic pop;
    } xfer_t;

endpackage

// File: rtl/pf_store.sv
// Storage array of the preloaded FIFO.
// One register slot per entry; slots below PRELOAD_N take a value from
// PRELOAD_DATA on reset, the remaining slots are left unreset.
// Assumes wr_en already includes the clock enable and the push qualification.
module pf_store #(
    parameter int WIDTH     = 8,
    parameter int DEPTH     = 8,
    parameter int PRELOAD_N = 0,
    parameter logic [DEPTH*WIDTH-1:0] PRELOAD_DATA = '0,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_data
);

    logic [DEPTH*WIDTH-1:0] slots_flat;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [WIDTH-1:0] slot_q;
        logic             hit;

        assign hit = wr_en && (wr_addr == AW'(g));

        if (g < PRELOAD_N) begin : g_seeded
            // Seeded slot: loads its preload word on reset, else takes writes.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    slot_q <= PRELOAD_DATA[g*WIDTH +: WIDTH];
                end else if (hit) begin
                    slot_q <= wr_data;
                end
            end
        end else begin : g_plain
            // Unseeded slot: content is don't-care until first written.
            always_ff @(posedge clk) begin
                if (hit) begin
                    slot_q <= wr_data;
                end
            end
        end

        assign slots_flat[g*WIDTH +: WIDTH] = slot_q;
    end

    // Head word read out without a register stage.
    always_comb begin
        rd_data = slots_flat[rd_addr*WIDTH +: WIDTH];
    end

endmodule

// File: rtl/pf_ctl.sv
// Pointer and flag control of the preloaded FIFO.
// Keeps read/write pointers and the occupancy, and drives in_ready and
// out_valid straight from registers so no input reaches an output within
// a cycle. Assumes DEPTH is a power of two, at least 2, and
// PRELOAD_N <= DEPTH.
module pf_ctl
    import preload_fifo_pkg::*;
#(
    parameter int DEPTH     = 8,
    parameter int PRELOAD_N = 0,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          in_valid,
    input  logic          out_ready,
    output logic          in_ready,
    output logic          out_valid,
    output logic          wr_en,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] rd_ptr,
    output logic [CW-1:0] occ
);

    localparam logic [CW-1:0] OCC_INIT = CW'(PRELOAD_N);
    localparam logic [CW-1:0] OCC_FULL = CW'(DEPTH);
    localparam logic [AW-1:0] WR_INIT  = AW'(PRELOAD_N % DEPTH);

    xfer_t         xf;
    logic [CW-1:0] occ_nxt;

    // Transfers are judged against the registered flags only.
    always_comb begin
        xf.push = en && in_valid && in_ready;
        xf.pop  = en && out_valid && out_ready;
    end

    // Occupancy after this cycle's transfers.
    always_comb begin
        occ_nxt = occ + CW'(xf.push) - CW'(xf.pop);
    end

    assign wr_en = xf.push;

    // Pointer, occupancy and flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr    <= '0;
            wr_ptr    <= WR_INIT;
            occ       <= OCC_INIT;
            in_ready  <= (PRELOAD_N < DEPTH);
            out_valid <= (PRELOAD_N > 0);
        end else if (en) begin
            if (xf.push) begin
                wr_ptr <= wr_ptr + 1'b1;
            end
            if (xf.pop) begin
                rd_ptr <= rd_ptr + 1'b1;
            end
            occ       <= occ_nxt;
            in_ready  <= (occ_nxt != OCC_FULL);
            out_valid <= (occ_nxt != '0);
        end
    end

endmodule

// File: rtl/preload_fifo.sv
// Preloaded valid/ready FIFO buffer (top).
// Holds PRELOAD_N words from PRELOAD_DATA right after reset, entry 0 first.
// Handshake outputs are registered. Assumes DEPTH is a power of two >= 2.
module preload_fifo #(
    parameter int WIDTH     = 8,
    parameter int DEPTH     = 8,
    parameter int PRELOAD_N = 3,
    parameter logic [DEPTH*WIDTH-1:0] PRELOAD_DATA = 64'h0000_0000_00C3_B2A1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [WIDTH-1:0] in_data,
    input  logic             in_valid,
    output logic             in_ready,
    output logic [WIDTH-1:0] out_data,
    output logic             out_valid,
    input  logic             out_ready
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic          wr_en;
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [CW-1:0] occ;

    pf_ctl #(
        .DEPTH    (DEPTH),
        .PRELOAD_N(PRELOAD_N)
    ) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .in_valid (in_valid),
        .out_ready(out_ready),
        .in_ready (in_ready),
        .out_valid(out_valid),
        .wr_en    (wr_en),
        .wr_ptr   (wr_ptr),
        .rd_ptr   (rd_ptr),
        .occ      (occ)
    );

    pf_store #(
        .WIDTH       (WIDTH),
        .DEPTH       (DEPTH),
        .PRELOAD_N   (PRELOAD_N),
        .PRELOAD_DATA(PRELOAD_DATA)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_addr(wr_ptr),
        .wr_data(in_data),
        .rd_addr(rd_ptr),
        .rd_data(out_data)
    );

endmodule

// File: rtl/pf_chk.sv
// Property checker for the preloaded FIFO, bound to the top module.
// Observes the ports and the internal occupancy count.
module pf_chk #(
    parameter int WIDTH     = 8,
    parameter int DEPTH     = 8,
    parameter int PRELOAD_N = 3,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             in_valid,
    input logic             in_ready,
    input logic [WIDTH-1:0] out_data,
    input logic             out_valid,
    input logic             out_ready,
    input logic [CW-1:0]    occ
);

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (occ == CW'(PRELOAD_N)) && (out_valid == (PRELOAD_N > 0)));

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CW'(DEPTH));

    assert_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> occ <= $past(occ));

    assert_hold_head_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> out_valid && $stable(out_data));

    assert_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(occ) && $stable(in_ready) && $stable(out_valid));

    assert_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid == (occ != '0)) && (in_ready == (occ < CW'(DEPTH))));

    assert_full_refuse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |=> occ <= $past(occ));

endmodule

bind preload_fifo pf_chk #(
    .WIDTH    (WIDTH),
    .DEPTH    (DEPTH),
    .PRELOAD_N(PRELOAD_N)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .out_data (out_data),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .occ      (occ)
);

// File: tb/preload_fifo_bench.sv
// Scoreboard bench for the preloaded FIFO: inputs change 2 time units after
// a rising edge, all observation happens at the falling edge.
module preload_fifo_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WIDTH      = 8;
    localparam int DEPTH      = 4;
    localparam int PRELOAD_N  = 2;
    localparam logic [DEPTH*WIDTH-1:0] PRELOAD_DATA = 32'h0000_5A3C;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             en = 1'b1;
    logic [WIDTH-1:0] in_data = '0;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [WIDTH-1:0] out_data;
    logic             out_valid;
    logic             out_ready = 1'b0;

    int n_checks = 0;
    int n_err    = 0;
    bit done     = 1'b0;
    logic [WIDTH-1:0] sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    preload_fifo #(
        .WIDTH       (WIDTH),
        .DEPTH       (DEPTH),
        .PRELOAD_N   (PRELOAD_N),
        .PRELOAD_DATA(PRELOAD_DATA)
    ) u_preload_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .in_data  (in_data),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .out_data (out_data),
        .out_valid(out_valid),
        .out_ready(out_ready)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    // Driver: offer a word until accepted, then record it as expected.
    task automatic push_word(input logic [WIDTH-1:0] d);
        bit acc;
        in_valid = 1'b1;
        in_data  = d;
        do begin
            @(negedge clk);
            acc = in_ready && en;
            if (acc) sb_q.push_back(d);
            step();
        end while (!acc);
        in_valid = 1'b0;
    endtask

    // Monitor: a pop will occur at the next edge; compare the head word (R3).
    always @(negedge clk) begin
        if (rst_n && en && out_valid && out_ready) begin
            if (sb_q.size() == 0) begin
                chk("R9 pop with nothing expected", 32'(out_data), 32'hFFFF_FFFF);
            end else begin
                chk("R3 order", 32'(out_data), 32'(sb_q[0]));
                void'(sb_q.pop_front());
            end
        end
    end

    initial begin
        logic [WIDTH-1:0] held;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        sb_q = {8'h3C, 8'h5A};

        // R1: preload visible right after reset
        @(negedge clk);
        chk("R1 out_valid", 32'(out_valid), 32'd1);
        chk("R1 head word", 32'(out_data), 32'h3C);
        chk("R2 in_ready after reset", 32'(in_ready), 32'd1);
        step();

        // R4: data present but in_valid low for several cycles
        in_data = 8'hEE;
        repeat (3) step();
        @(negedge clk);
        chk("R4 in_ready unchanged", 32'(in_ready), 32'd1);
        step();

        // R2: exactly DEPTH-PRELOAD_N pushes fit
        push_word(8'h01);
        push_word(8'h02);
        @(negedge clk);
        chk("R2 full after two pushes", 32'(in_ready), 32'd0);
        step();

        // R8: push and pop together when full; push refused
        out_ready = 1'b1;
        in_valid  = 1'b1;
        in_data   = 8'h99;
        @(negedge clk);
        chk("R8 in_ready low during pop", 32'(in_ready), 32'd0);
        step();
        out_ready = 1'b0;
        in_valid  = 1'b0;
        @(negedge clk);
        chk("R8 in_ready rises after pop", 32'(in_ready), 32'd1);
        chk("R8 head advanced", 32'(out_data), 32'h5A);
        step();
        push_word(8'h03);

        // R5: consumer stalls, head holds
        @(negedge clk);
        held = out_data;
        step();
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R5 out_valid held", 32'(out_valid), 32'd1);
            chk("R5 out_data held", 32'(out_data), 32'(held));
            step();
        end

        // R6: enable low freezes everything
        en = 1'b0;
        out_ready = 1'b1;
        in_valid = 1'b1;
        in_data = 8'hEE;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R6 out_data frozen", 32'(out_data), 32'h5A);
            chk("R6 in_ready frozen", 32'(in_ready), 32'd0);
            step();
        end
        en = 1'b1;
        in_valid = 1'b0;
        out_ready = 1'b0;
        step();

        // R10: out_ready change does not reach in_ready within the cycle
        out_ready = 1'b1;
        #1;
        chk("R10 in_ready unchanged by out_ready", 32'(in_ready), 32'd0);
        step();

        // R3: drain the rest in order
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (!out_valid) break;
            step();
        end
        chk("R3 scoreboard drained", 32'(sb_q.size()), 32'd0);
        chk("R9 out_valid low when empty", 32'(out_valid), 32'd0);
        step();

        // R9/R10/R7: push into empty with out_ready high
        in_valid = 1'b1;
        in_data = 8'h77;
        #1;
        chk("R10 out_valid unchanged by in_valid", 32'(out_valid), 32'd0);
        @(negedge clk);
        chk("R9 accept into empty", 32'(in_ready), 32'd1);
        chk("R7 no output in accept cycle", 32'(out_valid), 32'd0);
        sb_q.push_back(8'h77);
        step();
        in_valid = 1'b0;
        @(negedge clk);
        chk("R7 out_valid one cycle later", 32'(out_valid), 32'd1);
        chk("R7 word visible", 32'(out_data), 32'h77);
        step();
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R4 R9 stays empty", 32'(out_valid), 32'd0);
            step();
        end

        // R1: reset again restores the preload
        rst_n = 1'b0;
        out_ready = 1'b0;
        step();
        step();
        sb_q.delete();
        sb_q = {8'h3C, 8'h5A};
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 head after second reset", 32'(out_data), 32'h3C);
        chk("R1 out_valid after second reset", 32'(out_valid), 32'd1);
        step();
        out_ready = 1'b1;
        for (int i = 0; i < 4; i++) step();
        @(negedge clk);
        chk("R3 preload drained", 32'(sb_q.size()), 32'd0);
        chk("R9 empty after preload drain", 32'(out_valid), 32'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

endmodule